// File: doc/BRIEF.md
# Serial Command Port for a Reader Front End

This block is the microcontroller-facing port of a contactless reader front end. A host drives a serial clock and a data line into it and reads answers back on a data output. A frame opens when the data line rises while the serial clock is high. Command bits are then sampled on each rising serial-clock edge, most significant bit first. Two short opcodes, three bits long, switch the block into a streaming mode as soon as their third bit arrives. All other commands are eight bits long and are decoded once the eighth bit is in.

The block holds four 4-bit configuration pages, a 6-bit sampling time and a 4-bit write pulse width, and it exposes all of them as outputs. Read commands return one 8-bit answer, most significant bit first. The block drives each answer bit while the serial clock is low, so the bit is stable through the following high phase. In receive-streaming mode the digitized receive bit goes straight to the data output. In write mode the block raises a write request for the pulse timer that sits outside it. Either streaming mode ends at the next rising edge of the serial clock.

The serial clock and data inputs are expected to be synchronous to `clk` already. They are sampled once per system clock.

Top module: `sercmd_port`

## Requirements
- R1: A rising edge of `sdin` while `sclk` was high on this and the previous system clock starts a new frame. Any bits already shifted in are discarded, and a partial command writes nothing.
- R2: Command bits are sampled on rising edges of `sclk`, most significant bit first.
- R3: Bits 111 as the first three bits put the block in receive-streaming mode (`rd_mode`=1) after the third bit. While in that mode, `sdout` equals `rx_bit`.
- R4: Bits 110 as the first three bits put the block in write mode (`wr_mode`=1) after the third bit. `pulse_n` keeps the last programmed value.
- R5: Code 0001NNNN stores NNNN in `pulse_n` and enters write mode.
- R6: Code 10DDDDDD stores DDDDDD in `samp_time`. Code 00000010 answers {2'b00, samp_time}.
- R7: Code 01PPDDDD stores DDDD in page PP, which appears at `cfg_pages[4*PP +: 4]`. Code 000001PP answers with the page in bits 3:0. For PP of 0 or 1, bits 7:4 carry `pulse_n`. For PP of 2 or 3, bits 7:4 carry {0, 0, `amp_above`, `ant_fail`}.
- R8: Code 00001000 answers {2'b00, `phase_in`}.
- R9: Either streaming mode is left on the next rising edge of `sclk`. While the block is streaming, the pages and the sampling time do not change.
- R10: After reset, `cfg_pages` is 16'h0008 (only bit 3 of page 0 is set), `pulse_n` is 0, `samp_time` is 0, both modes are 0 and `sdout` is 1.
- R11: Any 8-bit code that matches no command changes no register and produces no answer (`sdout` stays 1).
- R12: Answer bits appear on the falling edges of `sclk` that follow the command, most significant bit first. After the eighth answer bit, the next falling edge returns `sdout` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial data to the host, idle high |
| rx_bit | input | 1 | Digitized receive bit |
| phase_in | input | 6 | Measured antenna phase |
| amp_above | input | 1 | Amplitude comparison status |
| ant_fail | input | 1 | Antenna failure status |
| rd_mode | output | 1 | Receive-streaming mode active |
| wr_mode | output | 1 | Write mode request |
| pulse_n | output | 4 | Stored write pulse width |
| samp_time | output | 6 | Stored sampling time |
| cfg_pages | output | 16 | Four configuration pages, page 0 in the low nibble |

## Verification
The assertions assume that `sclk` holds each level for more than one system clock. They also assume that `sdin` changes only while `sclk` is low, except when the host opens a frame. Under those conditions a start cannot coincide with a rising clock edge, and a write mode begun by code 0001NNNN is still active when `pulse_n` changes.

The bench enforces both conditions. It holds every serial phase for four system clocks and moves `sdin` only in low phases, or in the one high phase used to open a frame. Random command mixes are sent this way, alongside directed restarts, unknown codes and streaming exits.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int CMD_W    = 8;
    localparam int SHORT_W  = 3;
    localparam int PG_W     = 4;
    localparam int PG_NUM   = 4;
    localparam int PG_SEL_W = $clog2(PG_NUM);
    localparam int ST_W     = 6;
    localparam int PH_W     = 6;
    localparam int N_W      = 4;
    localparam int CNT_W    = $clog2(CMD_W + 1);

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_RDSTR,
        FR_WRSTR
    } frame_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_SET_ST,
        OP_SET_PG,
        OP_WR_N,
        OP_GET_PH,
        OP_GET_ST,
        OP_GET_PG
    } op_e;

    typedef enum logic [1:0] {
        SH_NONE,
        SH_READ,
        SH_WRITE
    } short_e;

    typedef struct packed {
        logic start;
        logic rise;
        logic fall;
        logic din;
    } sev_t;

    function automatic short_e decode_short(input logic [SHORT_W-1:0] b);
        case (b)
            3'b111:  return SH_READ;
            3'b110:  return SH_WRITE;
            default: return SH_NONE;
        endcase
    endfunction

    function automatic op_e decode_full(input logic [CMD_W-1:0] c);
        if (c[7:6] == 2'b10)             return OP_SET_ST;
        else if (c[7:6] == 2'b01)        return OP_SET_PG;
        else if (c[7:4] == 4'b0001)      return OP_WR_N;
        else if (c == 8'b0000_1000)      return OP_GET_PH;
        else if (c == 8'b0000_0010)      return OP_GET_ST;
        else if (c[7:2] == 6'b0000_01)   return OP_GET_PG;
        else                             return OP_NOP;
    endfunction

    function automatic logic is_get(input op_e op);
        return (op == OP_GET_PH) || (op == OP_GET_ST) || (op == OP_GET_PG);
    endfunction

    function automatic logic [PG_W-1:0] page_reset(input int idx);
        return (idx == 0) ? 4'b1000 : 4'b0000;
    endfunction

endpackage

// File: rtl/sercmd_edge.sv
module sercmd_edge
    import sercmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sdin,
    output sev_t ev
);
    logic sclk_q;
    logic sdin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sdin_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sdin_q <= sdin;
        end
    end

    always_comb begin
        ev.rise  = sclk & ~sclk_q;
        ev.fall  = ~sclk & sclk_q;
        ev.start = sdin & ~sdin_q & sclk & sclk_q;
        ev.din   = sdin;
    end
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
    import sercmd_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int SW = SHORT_W,
    parameter int KW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  sev_t          ev,
    output op_e           op,
    output logic          op_vld,
    output logic [CW-1:0] cmd,
    output logic          rd_mode,
    output logic          wr_mode
);
    localparam logic [KW-1:0] LAST_SHORT = KW'(SW - 1);
    localparam logic [KW-1:0] LAST_FULL  = KW'(CW - 1);

    frame_e        st;
    logic [CW-1:0] sh;
    logic [KW-1:0] cnt;
    logic [CW-1:0] nxt;
    op_e           nxt_op;

    assign nxt    = {sh[CW-2:0], ev.din};
    assign nxt_op = decode_full(nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FR_IDLE;
            sh     <= '0;
            cnt    <= '0;
            op     <= OP_NOP;
            op_vld <= 1'b0;
            cmd    <= '0;
        end else begin
            op_vld <= 1'b0;
            if (ev.start) begin
                st  <= FR_SHIFT;
                sh  <= '0;
                cnt <= '0;
            end else begin
                case (st)
                    FR_SHIFT: begin
                        if (ev.rise) begin
                            sh  <= nxt;
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_SHORT) begin
                                case (decode_short(nxt[SW-1:0]))
                                    SH_READ:  st <= FR_RDSTR;
                                    SH_WRITE: st <= FR_WRSTR;
                                    default:  st <= FR_SHIFT;
                                endcase
                            end else if (cnt == LAST_FULL) begin
                                op     <= nxt_op;
                                op_vld <= 1'b1;
                                cmd    <= nxt;
                                st     <= (nxt_op == OP_WR_N) ? FR_WRSTR : FR_IDLE;
                            end
                        end
                    end
                    FR_RDSTR, FR_WRSTR: begin
                        if (ev.rise) st <= FR_IDLE;
                    end
                    default: st <= FR_IDLE;
                endcase
            end
        end
    end

    assign rd_mode = (st == FR_RDSTR);
    assign wr_mode = (st == FR_WRSTR);
endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
    import sercmd_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int PW = PG_W,
    parameter int PN = PG_NUM,
    parameter int TW = ST_W,
    parameter int HW = PH_W,
    parameter int NW = N_W
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             op_vld,
    input  logic [CW-1:0]    cmd,
    input  logic [HW-1:0]    phase_in,
    input  logic             amp_above,
    input  logic             ant_fail,
    output logic [PN*PW-1:0] cfg_pages,
    output logic [TW-1:0]    samp_time,
    output logic [NW-1:0]    pulse_n,
    output logic             rsp_vld,
    output logic [CW-1:0]    rsp_data
);
    localparam int SELW = $clog2(PN);

    logic [PW-1:0]   pages [PN];
    logic [SELW-1:0] wsel;
    logic [SELW-1:0] rsel;
    logic [CW-1:0]   rsp_nxt;

    assign wsel = cmd[PW +: SELW];
    assign rsel = cmd[SELW-1:0];

    for (genvar g = 0; g < PN; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst)
                pages[g] <= page_reset(g);
            else if (op_vld && op == OP_SET_PG && wsel == SELW'(g))
                pages[g] <= cmd[PW-1:0];
        end
        assign cfg_pages[g*PW +: PW] = pages[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_time <= '0;
            pulse_n   <= '0;
        end else if (op_vld) begin
            if (op == OP_SET_ST) samp_time <= cmd[TW-1:0];
            if (op == OP_WR_N)   pulse_n   <= cmd[NW-1:0];
        end
    end

    always_comb begin
        rsp_nxt = '0;
        case (op)
            OP_GET_PH: rsp_nxt = CW'(phase_in);
            OP_GET_ST: rsp_nxt = CW'(samp_time);
            OP_GET_PG: begin
                if (rsel < SELW'(2))
                    rsp_nxt = {pulse_n, pages[rsel]};
                else
                    rsp_nxt = {2'b00, amp_above, ant_fail, pages[rsel]};
            end
            default: rsp_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_vld  <= op_vld && is_get(op);
            rsp_data <= rsp_nxt;
        end
    end
endmodule

// File: rtl/sercmd_tx.sv
module sercmd_tx
    import sercmd_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int KW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  sev_t          ev,
    input  logic          load,
    input  logic [CW-1:0] data,
    output logic          sdo
);
    localparam logic [KW-1:0] ALL_SENT = KW'(CW);

    logic [CW-1:0] buf_q;
    logic [KW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            sdo    <= 1'b1;
        end else if (ev.start) begin
            active <= 1'b0;
            sdo    <= 1'b1;
        end else if (load) begin
            buf_q  <= data;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && ev.fall) begin
            if (cnt == ALL_SENT) begin
                active <= 1'b0;
                sdo    <= 1'b1;
            end else begin
                sdo   <= buf_q[CW-1];
                buf_q <= {buf_q[CW-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sercmd_port.sv
module sercmd_port
    import sercmd_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int PW = PG_W,
    parameter int PN = PG_NUM,
    parameter int TW = ST_W,
    parameter int HW = PH_W,
    parameter int NW = N_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             sdin,
    output logic             sdout,
    input  logic             rx_bit,
    input  logic [HW-1:0]    phase_in,
    input  logic             amp_above,
    input  logic             ant_fail,
    output logic             rd_mode,
    output logic             wr_mode,
    output logic [NW-1:0]    pulse_n,
    output logic [TW-1:0]    samp_time,
    output logic [PN*PW-1:0] cfg_pages
);
    sev_t          ev;
    op_e           op;
    logic          op_vld;
    logic [CW-1:0] cmd;
    logic          rsp_vld;
    logic [CW-1:0] rsp_data;
    logic          tx_out;

    sercmd_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .sdin (sdin),
        .ev   (ev)
    );

    sercmd_ctrl #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .op      (op),
        .op_vld  (op_vld),
        .cmd     (cmd),
        .rd_mode (rd_mode),
        .wr_mode (wr_mode)
    );

    sercmd_regs #(.CW(CW), .PW(PW), .PN(PN), .TW(TW), .HW(HW), .NW(NW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .op_vld    (op_vld),
        .cmd       (cmd),
        .phase_in  (phase_in),
        .amp_above (amp_above),
        .ant_fail  (ant_fail),
        .cfg_pages (cfg_pages),
        .samp_time (samp_time),
        .pulse_n   (pulse_n),
        .rsp_vld   (rsp_vld),
        .rsp_data  (rsp_data)
    );

    sercmd_tx #(.CW(CW)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .load (rsp_vld),
        .data (rsp_data),
        .sdo  (tx_out)
    );

    assign sdout = rd_mode ? rx_bit : tx_out;
endmodule

// File: rtl/sercmd_port_chk.sv
module sercmd_port_chk #(
    parameter int PW = 16,
    parameter int TW = 6,
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sclk,
    input logic          rd_mode,
    input logic          wr_mode,
    input logic [NW-1:0] pulse_n,
    input logic [TW-1:0] samp_time,
    input logic [PW-1:0] cfg_pages
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk;
    end

    // R9: a rising serial clock ends receive streaming
    a_r9_rd_exit: assert property (@(posedge clk) disable iff (rst)
        (rd_mode && sclk && !sclk_d) |=> !rd_mode);

    // R9 / R4: a rising serial clock ends write mode
    a_r4_wr_exit: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && sclk && !sclk_d) |=> !wr_mode);

    // R9: pages and sampling time hold while streaming
    a_r9_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        (rd_mode || wr_mode) |=> ($stable(cfg_pages) && $stable(samp_time)));

    // R10: values right after reset
    a_r10_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_pages == PW'(16'h0008) && pulse_n == '0 &&
                        samp_time == '0 && !rd_mode && !wr_mode));

    // R5: pulse width only changes while write mode is active
    a_r5_n_in_write: assert property (@(posedge clk) disable iff (rst)
        (pulse_n != $past(pulse_n)) |-> $past(wr_mode));
endmodule

bind sercmd_port sercmd_port_chk #(.PW(PN*PW), .TW(TW), .NW(NW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .rd_mode   (rd_mode),
    .wr_mode   (wr_mode),
    .pulse_n   (pulse_n),
    .samp_time (samp_time),
    .cfg_pages (cfg_pages)
);

// File: tb/sercmd_port_bench.sv
`timescale 1ns/1ps
module sercmd_port_bench;
    localparam int HP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        sdout;
    logic        rx_bit = 1'b0;
    logic [5:0]  phase_in = '0;
    logic        amp_above = 1'b0;
    logic        ant_fail = 1'b0;
    logic        rd_mode;
    logic        wr_mode;
    logic [3:0]  pulse_n;
    logic [5:0]  samp_time;
    logic [15:0] cfg_pages;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] m_pg [4];
    logic [5:0] m_st;
    logic [3:0] m_n;

    always #5 clk = ~clk;

    sercmd_port u_sercmd_port (
        .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .sdout(sdout),
        .rx_bit(rx_bit), .phase_in(phase_in), .amp_above(amp_above),
        .ant_fail(ant_fail), .rd_mode(rd_mode), .wr_mode(wr_mode),
        .pulse_n(pulse_n), .samp_time(samp_time), .cfg_pages(cfg_pages)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cfg();
        return {m_pg[3], m_pg[2], m_pg[1], m_pg[0]};
    endfunction

    function automatic logic [7:0] exp_page(input int p);
        if (p < 2) return {m_n, m_pg[p]};
        return {2'b00, amp_above, ant_fail, m_pg[p]};
    endfunction

    task automatic check_regs(input string req);
        check(cfg_pages == exp_cfg(), {req, " pages"}, cfg_pages, exp_cfg());
        check(samp_time == m_st, {req, " samp"}, 16'(samp_time), 16'(m_st));
        check(pulse_n == m_n, {req, " pulse"}, 16'(pulse_n), 16'(m_n));
    endtask

    task automatic start_frame();
        sclk = 1'b0; sdin = 1'b0; hold(HP);
        sclk = 1'b1; hold(HP);
        sdin = 1'b1; hold(HP);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; sdin = v[7-i]; hold(HP);
            sclk = 1'b1; hold(HP);
        end
    endtask

    task automatic read_resp(output logic [7:0] r);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; hold(HP);
            sclk = 1'b1; hold(2);
            r[7-i] = sdout;
            hold(HP - 2);
        end
        sclk = 1'b0; hold(HP);
        sclk = 1'b1; hold(HP);
    endtask

    task automatic clock_exit();
        sclk = 1'b0; hold(HP);
        sclk = 1'b1; hold(HP);
    endtask

    task automatic do_set_page(input int p, input logic [3:0] d);
        start_frame(); send_bits({2'b01, 2'(p), d}, 8); hold(HP);
        m_pg[p] = d;
        check_regs("R7 set page");
    endtask

    task automatic do_set_st(input logic [5:0] d);
        start_frame(); send_bits({2'b10, d}, 8); hold(HP);
        m_st = d;
        check_regs("R6 set samp");
    endtask

    task automatic do_wr_n(input logic [3:0] n);
        start_frame(); send_bits({4'b0001, n}, 8); hold(HP);
        m_n = n;
        check(wr_mode == 1'b1, "R5 write mode", 16'(wr_mode), 16'd1);
        check_regs("R5 pulse stored");
        clock_exit();
        check(wr_mode == 1'b0, "R9 write exit", 16'(wr_mode), 16'd0);
    endtask

    task automatic do_get(input logic [7:0] code, input logic [7:0] exp, input string req);
        logic [7:0] r;
        start_frame(); send_bits(code, 8); hold(HP);
        read_resp(r);
        check(r == exp, req, 16'(r), 16'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd2024));
        m_pg[0] = 4'b1000; m_pg[1] = '0; m_pg[2] = '0; m_pg[3] = '0;
        m_st = '0; m_n = '0;
        hold(4);
        rst = 1'b0;
        hold(2);

        // R10 reset state
        check_regs("R10 reset");
        check(sdout == 1'b1, "R10 sdout idle", 16'(sdout), 16'd1);
        check({rd_mode, wr_mode} == 2'b00, "R10 modes", 16'({rd_mode, wr_mode}), 16'd0);
        do_get(8'b0000_0100, 8'h08, "R7 page0 after reset");

        // R2 / R6 MSB-first sampling time write and readback
        do_set_st(6'b100101);
        do_get(8'b0000_0010, {2'b00, 6'b100101}, "R6 R2 samp readback");

        // R1 restart discards a partial command
        start_frame(); send_bits(8'b1011_0000, 5);
        start_frame(); send_bits(8'b10_010011, 8); hold(HP);
        m_st = 6'b010011;
        check_regs("R1 restart");
        start_frame(); send_bits(8'b0111_0000, 6);
        start_frame(); hold(HP);
        check_regs("R1 partial no write");

        // R8 phase readback
        phase_in = 6'h2B;
        do_get(8'b0000_1000, 8'h2B, "R8 phase");

        // R3 short read stream with passthrough
        start_frame(); send_bits(8'b1110_0000, 3); hold(1);
        check(rd_mode == 1'b1, "R3 read stream", 16'(rd_mode), 16'd1);
        rx_bit = 1'b0; hold(1);
        check(sdout == 1'b0, "R3 pass 0", 16'(sdout), 16'd0);
        rx_bit = 1'b1; hold(1);
        check(sdout == 1'b1, "R3 pass 1", 16'(sdout), 16'd1);
        sclk = 1'b0; hold(HP);
        rx_bit = 1'b0; hold(1);
        check(sdout == 1'b0 && rd_mode, "R3 pass clock low", 16'(sdout), 16'd0);
        sclk = 1'b1; hold(HP);
        check(rd_mode == 1'b0, "R9 read exit", 16'(rd_mode), 16'd0);
        check_regs("R9 stream hold");

        // R5 then R4 short write keeps N
        do_wr_n(4'hA);
        start_frame(); send_bits(8'b1100_0000, 3); hold(1);
        check(wr_mode == 1'b1, "R4 short write", 16'(wr_mode), 16'd1);
        check(pulse_n == 4'hA, "R4 keeps N", 16'(pulse_n), 16'hA);
        clock_exit();
        check(wr_mode == 1'b0, "R9 short write exit", 16'(wr_mode), 16'd0);

        // R7 pages with status nibble
        do_set_page(2, 4'h5);
        amp_above = 1'b1; ant_fail = 1'b0;
        do_get(8'b0000_0110, exp_page(2), "R7 page2 status");
        do_set_page(1, 4'hC);
        do_get(8'b0000_0101, exp_page(1), "R7 page1 N nibble");

        // R11 unknown codes, R12 idle after answer
        foreach (r[i]) r[i] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] code;
            logic [7:0] got;
            code = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h0C : 8'h0F;
            start_frame(); send_bits(code, 8); hold(HP);
            read_resp(got);
            check(got == 8'hFF, "R11 no answer", 16'(got), 16'hFF);
            check_regs("R11 no change");
        end
        do_get(8'b0000_0010, {2'b00, m_st}, "R12 answer");
        check(sdout == 1'b1, "R12 idle after answer", 16'(sdout), 16'd1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int k;
            int p;
            k = int'($urandom % 6);
            p = int'($urandom % 4);
            case (k)
                0: do_set_page(p, 4'($urandom));
                1: do_set_st(6'($urandom));
                2: do_wr_n(4'($urandom));
                3: begin
                    amp_above = 1'($urandom); ant_fail = 1'($urandom);
                    do_get({6'b000001, 2'(p)}, exp_page(p), "R7 random page");
                end
                4: do_get(8'b0000_0010, {2'b00, m_st}, "R6 random samp");
                default: begin
                    phase_in = 6'($urandom);
                    do_get(8'b0000_1000, {2'b00, phase_in}, "R8 random phase");
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule